// File: doc/BRIEF.md
# Mode-Dependent Register Width Controller

This block keeps a processor's status byte, its hidden emulation bit and the registers whose width depends on the mode: the accumulator, two index registers, the stack pointer and the 8-bit program bank. Every write to these registers passes through width rules taken from three flags. The accumulator-width flag (M) limits accumulator writes to the low byte. The index-width flag (X) limits the index registers to 8 bits. The emulation bit (E) pins the stack to page one and holds both M and X at one.

A small two-state mode machine holds the emulation bit. Its states are `ST_EMU` (E=1) and `ST_NAT` (E=0). There is one command, the exchange, which swaps E with the carry flag. With carry at one the exchange takes transition `XCE_ENTER` (to `ST_EMU`). With carry at zero it takes `XCE_LEAVE` (to `ST_NAT`). In every other case, transition `HOLD` keeps the state. The status byte can be loaded whole, or have bits set or cleared by a mask. The read ports present each register already reduced to its effective width, so the surrounding datapath never applies the rules itself.

In any cycle, register writes obey the flags that result from that same cycle's status update. Results appear on the read ports after the next rising clock edge.

Top module: `wrc_top`

## Requirements
- R1: After reset: E=1, status reads 0x34, accumulator, X, Y and program bank read 0, and the stack pointer reads 0x0100.
- R2: Status bit positions are C=0, Z=1, I=2, D=3, X=4, M=5, V=6, N=7. The status command codes are 0 none, 1 load from the argument, 2 OR the argument in, 3 clear the bits set in the argument.
- R3: While E=1, status bits 5 and 4 read 1 whatever is loaded or cleared. Bit 4 is the break position in this mode.
- R4: E changes only on an exchange, which puts the old carry into E and the old E into carry. An exchange in the same cycle as a status command wins, and the command is ignored.
- R5: Entering E=1 sets M and X to 1, clears the high bytes of X and Y and sets the stack pointer high byte to 0x01, keeping its low byte.
- R6: While E=1 the stack pointer high byte reads 0x01, and a stack pointer write changes only the low byte. While E=0 a write sets all 16 bits.
- R7: With X=0, index writes store 16 bits. With X=1, index high bytes read 0, and a change of X from 0 to 1 clears them.
- R8: With M=1, accumulator writes change only the low byte, and the accumulator read port shows 0 in its high byte. The hidden high byte keeps its value and appears again once M returns to 0.
- R9: The program bank is an 8-bit register loaded by its write strobe, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| xce | input | 1 | Exchange carry with emulation bit |
| p_cmd | input | 2 | Status command: 0 none, 1 load, 2 set mask, 3 clear mask |
| p_arg | input | 8 | Status command argument |
| acc_we | input | 1 | Accumulator write strobe |
| acc_wd | input | 16 | Accumulator write data |
| x_we | input | 1 | X index write strobe |
| x_wd | input | 16 | X index write data |
| y_we | input | 1 | Y index write strobe |
| y_wd | input | 16 | Y index write data |
| sp_we | input | 1 | Stack pointer write strobe |
| sp_wd | input | 16 | Stack pointer write data |
| pb_we | input | 1 | Program bank write strobe |
| pb_wd | input | 8 | Program bank write data |
| p_q | output | 8 | Status byte |
| emu_q | output | 1 | Emulation bit |
| acc_q | output | 16 | Accumulator at effective width |
| x_q | output | 16 | X index at effective width |
| y_q | output | 16 | Y index at effective width |
| sp_q | output | 16 | Stack pointer with page forced in emulation |
| pb_q | output | 8 | Program bank |

## Verification
On every cycle, the assertions check the invariants that follow from the flags: M and X read 1 in emulation, the stack page is one, index and visible accumulator high bytes are zero when narrow, and the exchange swap holds together with a stable E when no exchange occurs. Some effects can only be seen through a sequence of commands, and the bench scenarios show them. These are the hidden accumulator high byte surviving an M=1 period, the index high bytes lost when X goes to one, the stack low byte kept on entry to emulation, and an exchange overriding a status command issued in the same cycle.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
    localparam int LO_W  = 8;
    localparam int HI_W  = 8;
    localparam int REG_W = LO_W + HI_W;

    localparam int FB_C = 0;
    localparam int FB_Z = 1;
    localparam int FB_I = 2;
    localparam int FB_D = 3;
    localparam int FB_X = 4;
    localparam int FB_M = 5;
    localparam int FB_V = 6;
    localparam int FB_N = 7;

    localparam logic [7:0] P_RESET = 8'h34;

    typedef enum logic {ST_NAT = 1'b0, ST_EMU = 1'b1} mode_e;
    typedef enum logic [1:0] {PC_NONE = 2'd0, PC_LOAD = 2'd1, PC_SET = 2'd2, PC_CLR = 2'd3} pcmd_e;
    typedef enum logic [1:0] {HI_KEEP = 2'd0, HI_ZERO = 2'd1, HI_FIX = 2'd2} hipol_e;
endpackage

// File: rtl/wrc_mode_ctl.sv
module wrc_mode_ctl
    import wrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xce,
    input  logic [1:0] p_cmd,
    input  logic [7:0] p_arg,
    output logic [7:0] p_q,
    output logic       emu_q,
    output logic       m_nx,
    output logic       x_nx,
    output logic       e_nx
);
    mode_e      st, st_nx;
    logic [7:0] p_r, p_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_EMU;
            p_r <= P_RESET;
        end else begin
            st  <= st_nx;
            p_r <= p_nx;
        end
    end

    // next state: XCE_ENTER / XCE_LEAVE on exchange, HOLD otherwise
    always_comb begin
        st_nx = st;
        p_nx  = p_r;
        if (xce) begin
            st_nx = p_r[FB_C] ? ST_EMU : ST_NAT;
            unique case (st)
                ST_EMU: p_nx[FB_C] = 1'b1;
                ST_NAT: p_nx[FB_C] = 1'b0;
            endcase
        end else begin
            unique case (pcmd_e'(p_cmd))
                PC_NONE: p_nx = p_r;
                PC_LOAD: p_nx = p_arg;
                PC_SET:  p_nx = p_r | p_arg;
                PC_CLR:  p_nx = p_r & ~p_arg;
            endcase
        end
        if (st_nx == ST_EMU) begin
            p_nx[FB_M] = 1'b1;
            p_nx[FB_X] = 1'b1;
        end
    end

    // outputs
    always_comb begin
        p_q   = p_r;
        emu_q = (st == ST_EMU);
        m_nx  = p_nx[FB_M];
        x_nx  = p_nx[FB_X];
        e_nx  = (st_nx == ST_EMU);
    end
endmodule

// File: rtl/wrc_width_reg.sv
module wrc_width_reg
    import wrc_pkg::*;
#(
    parameter int               LW     = 8,
    parameter int               HW     = 8,
    parameter hipol_e           POLICY = HI_KEEP,
    parameter logic [HW-1:0]    RST_HI = '0,
    parameter logic [HW-1:0]    FIX_HI = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [LW+HW-1:0] wd,
    input  logic             narrow,
    output logic [LW+HW-1:0] q
);
    localparam int W = LW + HW;

    logic [W-1:0] r, nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= {RST_HI, {LW{1'b0}}};
        else        r <= nx;
    end

    generate
        if (POLICY == HI_KEEP) begin : g_keep
            always_comb begin
                nx = r;
                if (we) nx = narrow ? {r[W-1:LW], wd[LW-1:0]} : wd;
            end
        end else if (POLICY == HI_ZERO) begin : g_zero
            always_comb begin
                nx = we ? wd : r;
                if (narrow) nx[W-1:LW] = '0;
            end
        end else begin : g_fix
            always_comb begin
                nx = we ? wd : r;
                if (narrow) nx[W-1:LW] = FIX_HI;
            end
        end
    endgenerate

    assign q = r;
endmodule

// File: rtl/wrc_top.sv
module wrc_top
    import wrc_pkg::*;
#(
    parameter int LW = wrc_pkg::LO_W,
    parameter int HW = wrc_pkg::HI_W,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xce,
    input  logic [1:0]       p_cmd,
    input  logic [7:0]       p_arg,
    input  logic             acc_we,
    input  logic [LW+HW-1:0] acc_wd,
    input  logic             x_we,
    input  logic [LW+HW-1:0] x_wd,
    input  logic             y_we,
    input  logic [LW+HW-1:0] y_wd,
    input  logic             sp_we,
    input  logic [LW+HW-1:0] sp_wd,
    input  logic             pb_we,
    input  logic [BW-1:0]    pb_wd,
    output logic [7:0]       p_q,
    output logic             emu_q,
    output logic [LW+HW-1:0] acc_q,
    output logic [LW+HW-1:0] x_q,
    output logic [LW+HW-1:0] y_q,
    output logic [LW+HW-1:0] sp_q,
    output logic [BW-1:0]    pb_q
);
    localparam logic [HW-1:0] STK_HI = HW'(1);

    logic         m_nx, x_nx, e_nx;
    logic [LW+HW-1:0] acc_raw;
    logic [BW-1:0]    pb_r;

    wrc_mode_ctl u_mode (
        .clk(clk), .rst_n(rst_n), .xce(xce), .p_cmd(p_cmd), .p_arg(p_arg),
        .p_q(p_q), .emu_q(emu_q), .m_nx(m_nx), .x_nx(x_nx), .e_nx(e_nx)
    );

    wrc_width_reg #(.LW(LW), .HW(HW), .POLICY(HI_KEEP)) u_acc (
        .clk(clk), .rst_n(rst_n), .we(acc_we), .wd(acc_wd), .narrow(m_nx), .q(acc_raw)
    );

    wrc_width_reg #(.LW(LW), .HW(HW), .POLICY(HI_ZERO)) u_x (
        .clk(clk), .rst_n(rst_n), .we(x_we), .wd(x_wd), .narrow(x_nx), .q(x_q)
    );

    wrc_width_reg #(.LW(LW), .HW(HW), .POLICY(HI_ZERO)) u_y (
        .clk(clk), .rst_n(rst_n), .we(y_we), .wd(y_wd), .narrow(x_nx), .q(y_q)
    );

    wrc_width_reg #(.LW(LW), .HW(HW), .POLICY(HI_FIX), .RST_HI(STK_HI), .FIX_HI(STK_HI)) u_sp (
        .clk(clk), .rst_n(rst_n), .we(sp_we), .wd(sp_wd), .narrow(e_nx), .q(sp_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pb_r <= '0;
        else if (pb_we) pb_r <= pb_wd;
    end

    assign pb_q  = pb_r;
    assign acc_q = p_q[FB_M] ? {{HW{1'b0}}, acc_raw[LW-1:0]} : acc_raw;
endmodule

// File: rtl/wrc_checker.sv
module wrc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        xce,
    input logic [7:0]  p_q,
    input logic        emu_q,
    input logic [15:0] acc_q,
    input logic [15:0] x_q,
    input logic [15:0] y_q,
    input logic [15:0] sp_q
);
    AST_EMU_MX_SET: assert property (@(posedge clk) disable iff (!rst_n)
        emu_q |-> p_q[5:4] == 2'b11); // R3
    AST_EMU_STK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        emu_q |-> sp_q[15:8] == 8'h01); // R6
    AST_IDX_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        p_q[4] |-> (x_q[15:8] == 8'h00 && y_q[15:8] == 8'h00)); // R7
    AST_ACC_HI_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        p_q[5] |-> acc_q[15:8] == 8'h00); // R8
    AST_XCE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        xce |=> (emu_q == $past(p_q[0]) && p_q[0] == $past(emu_q))); // R4
    AST_E_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !xce |=> $stable(emu_q)); // R4
    AST_ENTER_EMU: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(emu_q) |-> (p_q[5:4] == 2'b11 && x_q[15:8] == 8'h00)); // R5
endmodule

bind wrc_top wrc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .xce(xce), .p_q(p_q), .emu_q(emu_q),
    .acc_q(acc_q), .x_q(x_q), .y_q(y_q), .sp_q(sp_q)
);

// File: tb/sim_wrc_top.sv
`timescale 1ns/1ps
module sim_wrc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xce = 1'b0;
    logic [1:0]  p_cmd = 2'd0;
    logic [7:0]  p_arg = 8'h00;
    logic        acc_we = 1'b0, x_we = 1'b0, y_we = 1'b0, sp_we = 1'b0, pb_we = 1'b0;
    logic [15:0] acc_wd = '0, x_wd = '0, y_wd = '0, sp_wd = '0;
    logic [7:0]  pb_wd = '0;
    logic [7:0]  p_q;
    logic        emu_q;
    logic [15:0] acc_q, x_q, y_q, sp_q;
    logic [7:0]  pb_q;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference state
    bit          me;
    logic [7:0]  mp, mpb;
    logic [15:0] ma, mx, my, msp;

    always #5 clk = ~clk;

    wrc_top u0 (
        .clk(clk), .rst_n(rst_n), .xce(xce), .p_cmd(p_cmd), .p_arg(p_arg),
        .acc_we(acc_we), .acc_wd(acc_wd), .x_we(x_we), .x_wd(x_wd),
        .y_we(y_we), .y_wd(y_wd), .sp_we(sp_we), .sp_wd(sp_wd),
        .pb_we(pb_we), .pb_wd(pb_wd),
        .p_q(p_q), .emu_q(emu_q), .acc_q(acc_q), .x_q(x_q), .y_q(y_q),
        .sp_q(sp_q), .pb_q(pb_q)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] acc_view(input logic [15:0] a, input logic [7:0] p);
        return p[5] ? {8'h00, a[7:0]} : a;
    endfunction

    task automatic model_reset();
        me = 1'b1; mp = 8'h34; ma = '0; mx = '0; my = '0; msp = 16'h0100; mpb = '0;
    endtask

    task automatic model_step();
        bit         ne;
        logic [7:0] np;
        ne = me; np = mp;
        if (xce) begin
            ne = mp[0]; np[0] = me;
        end else begin
            case (p_cmd)
                2'd1: np = p_arg;
                2'd2: np = mp | p_arg;
                2'd3: np = mp & ~p_arg;
                default: np = mp;
            endcase
        end
        if (ne) np[5:4] = 2'b11;
        if (acc_we) ma = np[5] ? {ma[15:8], acc_wd[7:0]} : acc_wd;
        if (x_we) mx = x_wd;
        if (y_we) my = y_wd;
        if (np[4]) begin mx[15:8] = 8'h00; my[15:8] = 8'h00; end
        if (sp_we) msp = sp_wd;
        if (ne) msp[15:8] = 8'h01;
        if (pb_we) mpb = pb_wd;
        me = ne; mp = np;
    endtask

    task automatic compare_all();
        chk("R4 emu", {15'd0, emu_q}, {15'd0, me});
        chk("R3 status", {8'd0, p_q}, {8'd0, mp});
        chk("R8 acc", acc_q, acc_view(ma, mp));
        chk("R7 x", x_q, mx);
        chk("R7 y", y_q, my);
        chk("R6 sp", sp_q, msp);
        chk("R9 pb", {8'd0, pb_q}, {8'd0, mpb});
    endtask

    task automatic idle();
        xce = 0; p_cmd = 0; acc_we = 0; x_we = 0; y_we = 0; sp_we = 0; pb_we = 0;
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        idle();
    endtask

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk("R1 emu", {15'd0, emu_q}, 16'd1);
        chk("R1 status", {8'd0, p_q}, 16'h0034);
        chk("R1 acc", acc_q, 16'h0000);
        chk("R1 x", x_q, 16'h0000);
        chk("R1 sp", sp_q, 16'h0100);
        chk("R1 pb", {8'd0, pb_q}, 16'h0000);

        // R4: leave emulation (carry 0 after reset)
        xce = 1; step();
        chk("R4 leave", {15'd0, emu_q}, 16'd0);
        chk("R4 carry", {15'd0, p_q[0]}, 16'd1);
        // R2 clear M and X (bits 5,4)
        p_cmd = 2'd3; p_arg = 8'h30; step();
        chk("R2 clear mx", {8'd0, p_q}, 16'h0005);
        x_wd = 16'hABCD; x_we = 1; acc_wd = 16'h1234; acc_we = 1; sp_wd = 16'h2345; sp_we = 1; step();
        chk("R7 wide x", x_q, 16'hABCD);
        chk("R6 wide sp", sp_q, 16'h2345);
        // R7: X 0->1 clears high byte
        p_cmd = 2'd2; p_arg = 8'h10; step();
        chk("R7 x narrowed", x_q, 16'h00CD);
        // R8: M=1, low byte write, hidden high kept
        p_cmd = 2'd2; p_arg = 8'h20; step();
        acc_wd = 16'h99FF; acc_we = 1; step();
        chk("R8 narrow acc", acc_q, 16'h00FF);
        p_cmd = 2'd3; p_arg = 8'h20; step();
        chk("R8 hidden high", acc_q, 16'h12FF);
        // R5: enter emulation, carry is 1
        xce = 1; step();
        chk("R5 enter", {15'd0, emu_q}, 16'd1);
        chk("R5 sp page", sp_q, 16'h0145);
        // R4: exchange beats a status load in the same cycle
        xce = 1; p_cmd = 2'd1; p_arg = 8'hC0; step();
        chk("R4 cmd ignored", {8'd0, p_q}, 16'h0035);
        xce = 1; step();
        // R3: emulation keeps bits 5,4 against a zero load
        p_cmd = 2'd1; p_arg = 8'h00; step();
        chk("R3 forced bits", {8'd0, p_q}, 16'h0030);
        // R6: emulation stack write keeps page one
        sp_wd = 16'h7788; sp_we = 1; pb_wd = 8'hA5; pb_we = 1; step();
        chk("R6 emu sp", sp_q, 16'h0188);
        chk("R9 pb write", {8'd0, pb_q}, 16'h00A5);

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            xce    = ($urandom % 12) == 0;
            p_cmd  = (($urandom % 3) == 0) ? 2'($urandom) : 2'd0;
            p_arg  = 8'($urandom);
            acc_we = $urandom % 2; acc_wd = 16'($urandom);
            x_we   = $urandom % 2; x_wd   = 16'($urandom);
            y_we   = $urandom % 2; y_wd   = 16'($urandom);
            sp_we  = $urandom % 2; sp_wd  = 16'($urandom);
            pb_we  = $urandom % 2; pb_wd  = 8'($urandom);
            step();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule